// File: doc/BRIEF.md
# Image position offset controller

This block holds the horizontal and vertical position offsets that a video encoder applies to centre its output picture. Four direction controls (left, right, up, down) move the picture in fixed steps. Each control is the AND of a write-only register bit and an external pin. Either software or a set of toggle switches can therefore drive it, as long as the other source is held high.

A move takes place only when a combined control makes a full high-low-high toggle. The step is applied on the rising edge that ends the toggle. The offsets are signed and saturate at their limits. Certain display-mode round trips return both offsets to zero, which gives software a known reference for absolute positioning. The video timing and the scaler that consumes the offsets sit outside this block.

Top module: `img_pos_ctrl`

## Requirements
- R1: After the asynchronous reset, both offsets read 0 and all four direction register bits are 1.
- R2: A write with address 0x05 loads the direction bits from data bit 3 (left), bit 2 (right), bit 1 (up) and bit 0 (down). A write to any other address has no effect on them.
- R3: Each effective control is the direction bit ANDed with its pin, and the pin passes through a two-flop synchronizer first. While either source of a control is low, toggling the other source moves nothing.
- R4: A complete 1-0-1 toggle of an effective control moves its offset once by 4. Right adds 4 to the horizontal offset and left subtracts 4. Down adds 4 to the vertical offset and up subtracts 4. A falling edge alone moves nothing.
- R5: The offsets are 10-bit two's complement values. They saturate at +511 and -512 and never wrap.
- R6: When opposite directions complete a toggle in the same cycle, the offset on that axis is unchanged.
- R7: A mode sequence x, 0, x with x in 1..6 clears both offsets when the mode returns to x. The sequence 3, 0, 5 does not clear them.
- R8: The mode sequence 0, 1, 0 clears both offsets. The sequences 0, 2, 0 and 7, 0, 7 do not. The reset state counts as mode 0.
- R9: If a clearing mode change and a completed toggle fall in the same cycle, the clear wins and both offsets become 0.
- R10: The offsets change on the clock edge that follows the cycle in which the toggle completes or the mode input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| dir_pin_i | input | 4 | Direction pins: bit 3 left, 2 right, 1 up, 0 down (asynchronous) |
| mode_i | input | 3 | Display mode |
| h_ofs_o | output | 10 | Signed horizontal offset |
| v_ofs_o | output | 10 | Signed vertical offset |

## Verification
Two pairs of events can fall in the same cycle: a mode round trip that clears the offsets while a toggle completes, and opposite directions completing together. The bench provokes the first case by writing a direction bit back to 1 and changing the mode on the next falling clock edge. Both events then act on the same rising edge, and the bench expects zero offsets. It provokes the second by lowering and raising two opposite register bits in one write, and by toggling two opposite pins together. In both cases it expects the offset on that axis to be unchanged.

// File: rtl/img_pos_pkg.sv
package img_pos_pkg;
  localparam int N_DIR     = 4;
  localparam int DIR_DOWN  = 0;
  localparam int DIR_UP    = 1;
  localparam int DIR_RIGHT = 2;
  localparam int DIR_LEFT  = 3;
endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) st_q[s] <= '1;
    end else begin
      st_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/toggle_det.sv
module toggle_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic eff_i,
  output logic step_o
);
  // armed_q high after the control went low; the rise completes the toggle
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= ~eff_i;
  end

  assign step_o = armed_q & eff_i;
endmodule

// File: rtl/ofs_accum.sv
module ofs_accum #(
  parameter int W    = 10,
  parameter int STEP = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                clr_i,
  input  logic                inc_i,
  input  logic                dec_i,
  output logic signed [W-1:0] ofs_o
);
  localparam int XW = W + 2;
  localparam logic signed [XW-1:0] MAX_X  = XW'((2 ** (W - 1)) - 1);
  localparam logic signed [XW-1:0] MIN_X  = ~MAX_X;
  localparam logic signed [XW-1:0] STEP_X = XW'(STEP);

  logic signed [W-1:0]  ofs_q;
  logic signed [XW-1:0] cur_x, sum_x, sat_x;

  always_comb begin
    cur_x = $signed({{2{ofs_q[W-1]}}, ofs_q});
    sum_x = cur_x;
    if (inc_i) sum_x = sum_x + STEP_X;
    if (dec_i) sum_x = sum_x - STEP_X;
    if (sum_x > MAX_X)      sat_x = MAX_X;
    else if (sum_x < MIN_X) sat_x = MIN_X;
    else                    sat_x = sum_x;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ofs_q <= '0;
    else if (clr_i) ofs_q <= '0;
    else            ofs_q <= sat_x[W-1:0];
  end

  assign ofs_o = ofs_q;
endmodule

// File: rtl/mode_watch.sv
module mode_watch #(
  parameter int MODE_W  = 3,
  parameter int MODE_LO = 1,
  parameter int MODE_HI = 6,
  parameter int MODE_ALT = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [MODE_W-1:0] mode_i,
  output logic              clr_o
);
  localparam logic [MODE_W-1:0] LO  = MODE_W'(MODE_LO);
  localparam logic [MODE_W-1:0] HI  = MODE_W'(MODE_HI);
  localparam logic [MODE_W-1:0] ALT = MODE_W'(MODE_ALT);

  logic [MODE_W-1:0] cur_q, prev_q;
  logic chg, trip_a, trip_b;

  always_comb begin
    chg    = (mode_i != cur_q);
    // x -> 0 -> x with x in LO..HI
    trip_a = (cur_q == '0) && (prev_q >= LO) && (prev_q <= HI);
    // 0 -> ALT -> 0
    trip_b = (cur_q == ALT) && (prev_q == '0);
    clr_o  = chg && (mode_i == prev_q) && (trip_a || trip_b);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
    end else if (chg) begin
      prev_q <= cur_q;
      cur_q  <= mode_i;
    end
  end
endmodule

// File: rtl/img_pos_ctrl.sv
module img_pos_ctrl
  import img_pos_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int REG_ADDR    = 5,
  parameter int OFS_W       = 10,
  parameter int STEP        = 4,
  parameter int SYNC_STAGES = 2,
  parameter int MODE_W      = 3
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       wr_addr_i,
  input  logic [DATA_W-1:0]       wr_data_i,
  input  logic [N_DIR-1:0]        dir_pin_i,
  input  logic [MODE_W-1:0]       mode_i,
  output logic signed [OFS_W-1:0] h_ofs_o,
  output logic signed [OFS_W-1:0] v_ofs_o
);
  localparam logic [ADDR_W-1:0] REG_A = ADDR_W'(REG_ADDR);

  logic [N_DIR-1:0] dir_reg_q, pin_s, eff, step;
  logic             mode_clr;
  logic             reg_hit;

  assign reg_hit = wr_en_i && (wr_addr_i == REG_A);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      dir_reg_q <= '1;
    else if (reg_hit) dir_reg_q <= wr_data_i[N_DIR-1:0];
  end

  pin_sync #(.W(N_DIR), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (dir_pin_i),
    .q_o   (pin_s)
  );

  assign eff = dir_reg_q & pin_s;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    toggle_det u_tog (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .eff_i (eff[d]),
      .step_o(step[d])
    );
  end

  mode_watch #(.MODE_W(MODE_W)) u_mode (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .mode_i(mode_i),
    .clr_o (mode_clr)
  );

  ofs_accum #(.W(OFS_W), .STEP(STEP)) u_h (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mode_clr),
    .inc_i (step[DIR_RIGHT]),
    .dec_i (step[DIR_LEFT]),
    .ofs_o (h_ofs_o)
  );

  ofs_accum #(.W(OFS_W), .STEP(STEP)) u_v (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (mode_clr),
    .inc_i (step[DIR_DOWN]),
    .dec_i (step[DIR_UP]),
    .ofs_o (v_ofs_o)
  );
endmodule

// File: rtl/img_pos_ctrl_chk.sv
module img_pos_ctrl_chk #(
  parameter int ADDR_W   = 8,
  parameter int REG_ADDR = 5,
  parameter int OFS_W    = 10,
  parameter int STEP     = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    wr_en_i,
  input logic [ADDR_W-1:0]       wr_addr_i,
  input logic [3:0]              dir_reg_i,
  input logic                    clr_i,
  input logic signed [OFS_W-1:0] h_ofs_i,
  input logic signed [OFS_W-1:0] v_ofs_i
);
  logic signed [OFS_W-1:0] h_d, v_d;
  logic                    clr_d;
  logic signed [OFS_W:0]   dh, dv;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      h_d   <= '0;
      v_d   <= '0;
      clr_d <= 1'b0;
    end else begin
      h_d   <= h_ofs_i;
      v_d   <= v_ofs_i;
      clr_d <= clr_i;
    end
  end

  assign dh = $signed({h_ofs_i[OFS_W-1], h_ofs_i}) - $signed({h_d[OFS_W-1], h_d});
  assign dv = $signed({v_ofs_i[OFS_W-1], v_ofs_i}) - $signed({v_d[OFS_W-1], v_d});

  a_r2_reg_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && wr_addr_i == ADDR_W'(REG_ADDR)) |=> $stable(dir_reg_i));

  a_r3_blocked_h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_reg_i[3] && !dir_reg_i[2]) |=> ($stable(h_ofs_i) || h_ofs_i == '0));

  // R4: never more than one step per cycle, so no wrap
  a_r5_no_wrap_h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_d |-> (dh <= (OFS_W+1)'(STEP) && dh >= -(OFS_W+1)'(STEP)));

  a_r5_no_wrap_v: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_d |-> (dv <= (OFS_W+1)'(STEP) && dv >= -(OFS_W+1)'(STEP)));

  a_r9_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (h_ofs_i == '0 && v_ofs_i == '0));
endmodule

bind img_pos_ctrl img_pos_ctrl_chk #(
  .ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR), .OFS_W(OFS_W), .STEP(STEP)
) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .dir_reg_i(dir_reg_q),
  .clr_i    (mode_clr),
  .h_ofs_i  (h_ofs_o),
  .v_ofs_i  (v_ofs_o)
);

// File: tb/img_pos_ctrl_tb_top.sv
module img_pos_ctrl_tb_top;
  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              wr_en_i = 1'b0;
  logic [7:0]        wr_addr_i = '0;
  logic [7:0]        wr_data_i = '0;
  logic [3:0]        dir_pin_i = 4'hF;
  logic [2:0]        mode_i = '0;
  logic signed [9:0] h_ofs_o, v_ofs_o;

  int n_tests = 0;
  int n_fail  = 0;
  int exp_h   = 0;
  int exp_v   = 0;
  bit done    = 1'b0;

  always #5 clk_i = ~clk_i;

  img_pos_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .dir_pin_i(dir_pin_i), .mode_i(mode_i),
    .h_ofs_o(h_ofs_o), .v_ofs_o(v_ofs_o)
  );

  function automatic int sat(int x);
    if (x > 511)  return 511;
    if (x < -512) return -512;
    return x;
  endfunction

  task automatic check(string req, int act, int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_hv(string req);
    check(req, int'(h_ofs_o), exp_h);
    check(req, int'(v_ofs_o), exp_v);
  endtask

  task automatic reg_wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk_i);
  endtask

  // bit index: 3 left, 2 right, 1 up, 0 down
  task automatic reg_toggle(logic [3:0] mask);
    reg_wr(8'h05, {4'h0, ~mask});
    settle();
    reg_wr(8'h05, 8'h0F);
    settle();
  endtask

  task automatic pin_toggle(logic [3:0] mask);
    @(negedge clk_i); dir_pin_i = ~mask;
    settle();
    @(negedge clk_i); dir_pin_i = 4'hF;
    repeat (6) @(negedge clk_i);
  endtask

  task automatic set_mode(logic [2:0] m);
    @(negedge clk_i); mode_i = m;
    settle();
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    check_hv("R1 reset offsets");
    rst_ni = 1'b1;
    settle();
    check_hv("R1 offsets after reset release");
    // R1: direction bits are all 1, so a single raise of none moves nothing
    reg_wr(8'h05, 8'h0F);
    settle();
    check_hv("R1 register bits reset to 1");

    // R4/R5 right sweep to saturation
    for (int i = 0; i < 130; i++) begin
      reg_toggle(4'b0100);
      exp_h = sat(exp_h + 4);
      check("R4 right step / R5 upper saturation", int'(h_ofs_o), exp_h);
    end
    // left sweep to lower saturation
    for (int i = 0; i < 260; i++) begin
      reg_toggle(4'b1000);
      exp_h = sat(exp_h - 4);
      check("R4 left step / R5 lower saturation", int'(h_ofs_o), exp_h);
    end
    for (int i = 0; i < 10; i++) begin
      pin_toggle(4'b0001);
      exp_v = sat(exp_v + 4);
      check("R3 R4 down via pin", int'(v_ofs_o), exp_v);
    end
    for (int i = 0; i < 4; i++) begin
      pin_toggle(4'b0010);
      exp_v = sat(exp_v - 4);
      check("R3 R4 up via pin", int'(v_ofs_o), exp_v);
    end
    for (int i = 0; i < 3; i++) begin
      reg_toggle(4'b0100);
      exp_h = sat(exp_h + 4);
    end
    check_hv("R4 right after saturation");

    // R4 falling edge alone
    reg_wr(8'h05, 8'h07);
    settle();
    check_hv("R4 falling edge alone");
    reg_wr(8'h05, 8'h0F);
    settle();
    exp_h = exp_h - 4;
    check_hv("R4 rise completes toggle");

    // R3 pin low blocks register toggle
    @(negedge clk_i); dir_pin_i = 4'b1011;
    settle();
    reg_toggle(4'b0100);
    check_hv("R3 pin low blocks register toggle");
    @(negedge clk_i); dir_pin_i = 4'hF;
    repeat (6) @(negedge clk_i);
    exp_h = exp_h + 4;
    check_hv("R3 pin release completes toggle");
    // register low blocks pin toggle
    reg_wr(8'h05, 8'h0D);
    settle();
    pin_toggle(4'b0010);
    check_hv("R3 register low blocks pin toggle");
    reg_wr(8'h05, 8'h0F);
    settle();
    exp_v = exp_v - 4;
    check_hv("R3 register raise completes toggle");

    // R2 other address ignored
    reg_wr(8'h06, 8'h00);
    settle();
    reg_wr(8'h05, 8'h0F);
    settle();
    check_hv("R2 other address ignored");

    // R6 opposite directions together
    reg_toggle(4'b0011);
    check_hv("R6 up and down via register");
    pin_toggle(4'b1100);
    check_hv("R6 left and right via pins");

    // R8 0,1,0 clears
    set_mode(3'd1);
    check_hv("R8 mode 0 to 1 keeps offsets");
    set_mode(3'd0);
    exp_h = 0; exp_v = 0;
    check_hv("R8 mode 0,1,0 clears");
    reg_toggle(4'b0101);
    exp_h = 4; exp_v = 4;
    check_hv("R4 moves after clear");
    set_mode(3'd2);
    set_mode(3'd0);
    check_hv("R8 mode 0,2,0 keeps offsets");
    set_mode(3'd3);
    set_mode(3'd0);
    set_mode(3'd5);
    check_hv("R7 mode 3,0,5 keeps offsets");
    set_mode(3'd0);
    set_mode(3'd5);
    exp_h = 0; exp_v = 0;
    check_hv("R7 mode 5,0,5 clears");
    reg_toggle(4'b1010);
    exp_h = -4; exp_v = -4;
    set_mode(3'd7);
    set_mode(3'd0);
    set_mode(3'd7);
    check_hv("R8 mode 7,0,7 keeps offsets");
    set_mode(3'd0);
    set_mode(3'd4);
    set_mode(3'd0);
    reg_toggle(4'b0100);
    exp_h = 0;
    check_hv("R4 move in mode 0");

    // R9 clear and completed toggle in the same cycle
    reg_wr(8'h05, 8'h0B);
    settle();
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 8'h05; wr_data_i = 8'h0F;
    @(negedge clk_i);
    wr_en_i = 1'b0; mode_i = 3'd4;
    @(negedge clk_i);
    exp_h = 0; exp_v = 0;
    check_hv("R9 R10 clear wins over move");
    settle();
    check_hv("R9 offsets stay cleared");

    // R10 latency: one edge after toggle completes
    reg_wr(8'h05, 8'h0B);
    settle();
    reg_wr(8'h05, 8'h0F);
    check("R10 not yet moved", int'(h_ofs_o), 0);
    @(negedge clk_i);
    check("R10 moved one edge later", int'(h_ofs_o), 4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule